// File: doc/BRIEF.md
# Network Status Indicator and GPIO Pin Multiplexer

This block owns three shared pins. Each pin works either as a general-purpose I/O or as an active-low status lamp for an Ethernet link. In GPIO mode a pin is a push-pull output, an open-drain output or an input, chosen by per-pin configuration bits. In lamp mode the pin is always open-drain: it pulls low to light the lamp and releases the pad to turn it off.

The lamp roles are fixed by pin position:

- **Pin 0** shows speed.
- **Pin 1** shows link and activity.
- **Pin 2** shows duplex.

The link/activity lamp stays lit while the link is up. Transmit or receive traffic turns it off for one blink period. After that it stays lit for at least one more period before traffic can blink it again. A counter measures the period in system clocks, and `BLINK_CYCLES` sets its length. Pad input levels are resynchronised to the system clock before software reads them.

The block drives `padOut` and `padOe` toward the pad cells. It reads `padIn` back from those cells. The link inputs come from the PHY/MAC and are synchronous to `clk`.

Top module: `led_gpio_mux`

## Requirements
- R1: With `cfgLedEn[i]=0`, `cfgDir[i]=1` and `cfgOpenDrain[i]=0`, one clock after the inputs are sampled `padOe[i]` is 1 and `padOut[i]` equals `gpoData[i]`.
- R2: With `cfgLedEn[i]=0`, `cfgDir[i]=1` and `cfgOpenDrain[i]=1`, `padOut[i]` is 0 and `padOe[i]` is the inverse of `gpoData[i]`, one clock later. Writing 0 drives low; writing 1 floats the pin.
- R3: With `cfgLedEn[i]=0` and `cfgDir[i]=0`, `padOe[i]` is 0 one clock later, whatever `gpoData[i]` holds.
- R4: With `cfgLedEn[i]=1`, `padOut[i]` is 0. `padOe[i]=1` means the lamp is lit and `padOe[i]=0` means the pad is released.
- R5: The speed lamp (pin 0) is lit when `speed100`, `autoNegBusy` or `!linkUp` holds. It is dark only when the link is up at 10 Mb/s with no negotiation running. The lamp follows one clock after the inputs.
- R6: The link lamp (pin 1) is lit one clock after `linkUp` rises, and it stays lit while the link is idle.
- R7: A `txPulse` or `rxPulse` sampled at edge k while the link lamp is solid makes pin 1 dark from the cycle after edge k+1, for exactly `BLINK_CYCLES` cycles.
- R8: After every dark period pin 1 is lit for at least `BLINK_CYCLES` cycles. Activity seen during a dark or lit-hold period is remembered and starts the next dark period as soon as the hold ends. Without remembered activity the lamp stays solid.
- R9: The duplex lamp (pin 2) is lit one clock after `linkUp` and `fullDuplex` are both high, and dark otherwise.
- R10: When `linkUp` falls, pin 1 is dark the next clock and any blink in progress or pending is discarded. Activity while the link is down is ignored. A new link shows a solid lamp with no stale blink.
- R11: Clearing `cfgLedEn[i]` returns the pin to its GPIO setting one clock later.
- R12: `gpiData` reflects `padIn` through a two-stage synchronizer: a change appears two clocks later and not one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgDir | input | 3 | Per-pin GPIO direction, 1 = output |
| cfgOpenDrain | input | 3 | Per-pin GPIO output style, 1 = open-drain |
| cfgLedEn | input | 3 | Per-pin lamp mode select |
| gpoData | input | 3 | GPIO output data |
| linkUp | input | 1 | Valid link present |
| speed100 | input | 1 | Link runs at 100 Mb/s |
| autoNegBusy | input | 1 | Auto-negotiation in progress |
| fullDuplex | input | 1 | Link is full duplex |
| txPulse | input | 1 | One-clock transmit activity strobe |
| rxPulse | input | 1 | One-clock receive activity strobe |
| padIn | input | 3 | Levels read back from the pads |
| padOut | output | 3 | Pad drive value |
| padOe | output | 3 | Pad output enable |
| gpiData | output | 3 | Synchronized GPIO input data |

## Verification
The hardest condition to reach from the ports is remembered activity: a strobe that arrives while the lamp is already dark or in its minimum lit hold. Such a strobe must neither stretch the current period nor be lost. The bench times a second strobe a few cycles into a dark period, and in another run into the hold. It then checks the boundary cycles where the hold must end and the next dark period must start. A further sequence drops the link mid-blink and sends a strobe while the link is down. It then raises the link to confirm that nothing remembered survives.

// File: rtl/ledGpioPkg.sv
package ledGpioPkg;

  localparam int PIN_COUNT  = 3;
  localparam int PIN_SPEED  = 0;
  localparam int PIN_LINK   = 1;
  localparam int PIN_DUPLEX = 2;

  typedef enum logic [1:0] {
    BLINK_DOWN,
    BLINK_SOLID,
    BLINK_DARK,
    BLINK_HOLD
  } blinkState_t;

  // lamp requests from control to datapath, 1 = lamp lit
  typedef struct packed {
    logic duplexLit;
    logic linkLit;
    logic speedLit;
  } ledReq_t;

endpackage

// File: rtl/led_gpio_ctrl.sv
module led_gpio_ctrl
  import ledGpioPkg::*;
#(
  parameter int BLINK_CYCLES = 2000000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    linkUp,
  input  logic    speed100,
  input  logic    autoNegBusy,
  input  logic    fullDuplex,
  input  logic    txPulse,
  input  logic    rxPulse,
  output ledReq_t ledReq
);

  localparam int CW = (BLINK_CYCLES > 1) ? $clog2(BLINK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BLINK_CYCLES - 1);

  blinkState_t state, nextState;
  logic [CW-1:0] cnt, nextCnt;
  logic pending, nextPending;
  logic activity;

  assign activity = txPulse | rxPulse;

  always_comb begin
    nextState   = state;
    nextCnt     = cnt;
    nextPending = pending;
    unique case (state)
      BLINK_DOWN: begin
        nextPending = 1'b0;
        nextCnt     = '0;
        if (linkUp) nextState = BLINK_SOLID;
      end
      BLINK_SOLID: begin
        if (activity) begin
          nextState = BLINK_DARK;
          nextCnt   = '0;
        end
      end
      BLINK_DARK: begin
        if (activity) nextPending = 1'b1;
        if (cnt == LAST) begin
          nextState = BLINK_HOLD;
          nextCnt   = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      BLINK_HOLD: begin
        if (cnt == LAST) begin
          nextCnt = '0;
          if (pending || activity) begin
            nextState   = BLINK_DARK;
            nextPending = 1'b0;
          end else begin
            nextState = BLINK_SOLID;
          end
        end else begin
          nextCnt = cnt + 1'b1;
          if (activity) nextPending = 1'b1;
        end
      end
      default: nextState = BLINK_DOWN;
    endcase
    if (!linkUp) begin
      nextState   = BLINK_DOWN;
      nextCnt     = '0;
      nextPending = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= BLINK_DOWN;
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      state   <= nextState;
      cnt     <= nextCnt;
      pending <= nextPending;
    end
  end

  always_comb begin
    ledReq.speedLit  = !linkUp || speed100 || autoNegBusy;
    ledReq.linkLit   = linkUp && (state != BLINK_DARK);
    ledReq.duplexLit = linkUp && fullDuplex;
  end

  // R10: a lost link always lands in the idle state
  assert_drop_resets_R10: assert property (@(posedge clk) disable iff (!rstN)
    !linkUp |=> state == BLINK_DOWN);

  // R7: a dark period ends into the hold, never earlier
  assert_dark_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == BLINK_DARK && cnt != LAST && linkUp) |=> state == BLINK_DARK);

  // R8: the hold cannot be cut short by traffic
  assert_hold_guard_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == BLINK_HOLD && cnt != LAST && linkUp) |=> state == BLINK_HOLD);

  // R7: the period counter stays in range
  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST);

endmodule

// File: rtl/led_gpio_datapath.sv
module led_gpio_datapath
  import ledGpioPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] cfgDir,
  input  logic [PIN_COUNT-1:0] cfgOpenDrain,
  input  logic [PIN_COUNT-1:0] cfgLedEn,
  input  logic [PIN_COUNT-1:0] gpoData,
  input  ledReq_t              ledReq,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] gpiData
);

  logic [PIN_COUNT-1:0] ledLit;

  always_comb begin
    ledLit             = '0;
    ledLit[PIN_SPEED]  = ledReq.speedLit;
    ledLit[PIN_LINK]   = ledReq.linkLit;
    ledLit[PIN_DUPLEX] = ledReq.duplexLit;
  end

  for (genvar g = 0; g < PIN_COUNT; g++) begin : gPin
    always_ff @(posedge clk) begin
      if (!rstN) begin
        padOut[g] <= 1'b0;
        padOe[g]  <= 1'b0;
      end else if (cfgLedEn[g]) begin
        padOut[g] <= 1'b0;
        padOe[g]  <= ledLit[g];
      end else if (!cfgDir[g]) begin
        padOut[g] <= 1'b0;
        padOe[g]  <= 1'b0;
      end else if (cfgOpenDrain[g]) begin
        padOut[g] <= 1'b0;
        padOe[g]  <= !gpoData[g];
      end else begin
        padOut[g] <= gpoData[g];
        padOe[g]  <= 1'b1;
      end
    end

    // R4: a lamp pin never drives high
    assert_lamp_never_high_R4: assert property (@(posedge clk) disable iff (!rstN)
      cfgLedEn[g] |=> !(padOe[g] && padOut[g]));

    // R3: an input pin never enables its driver
    assert_input_floats_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!cfgLedEn[g] && !cfgDir[g]) |=> !padOe[g]);

    // R2: open-drain GPIO never drives high
    assert_od_never_high_R2: assert property (@(posedge clk) disable iff (!rstN)
      (!cfgLedEn[g] && cfgDir[g] && cfgOpenDrain[g]) |=> !(padOe[g] && padOut[g]));
  end

  logic [PIN_COUNT-1:0] syncChain [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk) begin
      if (!rstN) syncChain[s] <= '0;
      else if (s == 0) syncChain[s] <= padIn;
      else syncChain[s] <= syncChain[(s == 0) ? 0 : s - 1];
    end
  end

  assign gpiData = syncChain[SYNC_STAGES-1];

endmodule

// File: rtl/led_gpio_mux.sv
module led_gpio_mux
  import ledGpioPkg::*;
#(
  parameter int BLINK_CYCLES = 2000000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] cfgDir,
  input  logic [2:0] cfgOpenDrain,
  input  logic [2:0] cfgLedEn,
  input  logic [2:0] gpoData,
  input  logic       linkUp,
  input  logic       speed100,
  input  logic       autoNegBusy,
  input  logic       fullDuplex,
  input  logic       txPulse,
  input  logic       rxPulse,
  input  logic [2:0] padIn,
  output logic [2:0] padOut,
  output logic [2:0] padOe,
  output logic [2:0] gpiData
);

  ledReq_t ledReq;

  led_gpio_ctrl #(.BLINK_CYCLES(BLINK_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .linkUp(linkUp), .speed100(speed100),
    .autoNegBusy(autoNegBusy), .fullDuplex(fullDuplex),
    .txPulse(txPulse), .rxPulse(rxPulse), .ledReq(ledReq)
  );

  led_gpio_datapath #(.SYNC_STAGES(SYNC_STAGES)) datapath (
    .clk(clk), .rstN(rstN), .cfgDir(cfgDir), .cfgOpenDrain(cfgOpenDrain),
    .cfgLedEn(cfgLedEn), .gpoData(gpoData), .ledReq(ledReq),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .gpiData(gpiData)
  );

endmodule

// File: tb/led_gpio_mux_test.sv
module led_gpio_mux_test;

  localparam int B = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic [2:0] cfgDir, cfgOpenDrain, cfgLedEn, gpoData, padIn;
  logic linkUp, speed100, autoNegBusy, fullDuplex, txPulse, rxPulse;
  logic [2:0] padOut, padOe, gpiData;

  led_gpio_mux #(.BLINK_CYCLES(B), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .cfgDir(cfgDir), .cfgOpenDrain(cfgOpenDrain),
    .cfgLedEn(cfgLedEn), .gpoData(gpoData), .linkUp(linkUp),
    .speed100(speed100), .autoNegBusy(autoNegBusy), .fullDuplex(fullDuplex),
    .txPulse(txPulse), .rxPulse(rxPulse), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .gpiData(gpiData)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;

  typedef struct {
    int due;
    logic [2:0] oeCare, oeExp, outCare, outExp, gpiExp;
    bit gpiCare;
    string req;
  } item_t;

  item_t sb[$];

  function automatic void compare(item_t it);
    checks++;
    if ((((padOe ^ it.oeExp) & it.oeCare) !== 3'b000) ||
        (((padOut ^ it.outExp) & it.outCare) !== 3'b000) ||
        (it.gpiCare && (gpiData !== it.gpiExp))) begin
      fails++;
      $display("FAIL %s cycle %0d: oe=%b out=%b gpi=%b expected oe=%b/care %b out=%b/care %b gpi=%b",
               it.req, cyc, padOe, padOut, gpiData, it.oeExp, it.oeCare,
               it.outExp, it.outCare, it.gpiExp);
    end
  endfunction

  task automatic expectAt(int due, logic [2:0] oeCare, logic [2:0] oeExp,
                          logic [2:0] outCare, logic [2:0] outExp,
                          bit gpiCare, logic [2:0] gpiExp, string req);
    item_t it;
    it.due = due; it.oeCare = oeCare; it.oeExp = oeExp;
    it.outCare = outCare; it.outExp = outExp;
    it.gpiCare = gpiCare; it.gpiExp = gpiExp; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: compare every item due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        compare(sb[i]);
        sb.delete(i);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse(bit isTx);
    if (isTx) txPulse = 1'b1; else rxPulse = 1'b1;
    step(1);
    txPulse = 1'b0;
    rxPulse = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int c;
    item_t r;
    rstN = 1'b0;
    cfgDir = '0; cfgOpenDrain = '0; cfgLedEn = '0; gpoData = '0; padIn = '0;
    linkUp = 0; speed100 = 0; autoNegBusy = 0; fullDuplex = 0;
    txPulse = 0; rxPulse = 0;
    step(3);
    // reset state
    r.due = cyc; r.oeCare = 3'b111; r.oeExp = 3'b000; r.outCare = 3'b111;
    r.outExp = 3'b000; r.gpiCare = 1'b1; r.gpiExp = 3'b000; r.req = "reset";
    compare(r);
    rstN = 1'b1;
    step(1);

    // R3: input pins float
    gpoData = 3'b111; c = cyc;
    expectAt(c + 1, 3'b111, 3'b000, 3'b000, 3'b000, 0, 3'b000, "R3");
    step(2);

    // R1: push-pull
    cfgDir = 3'b111; gpoData = 3'b101; c = cyc;
    expectAt(c + 1, 3'b111, 3'b111, 3'b111, 3'b101, 0, 3'b000, "R1");
    step(1);
    gpoData = 3'b010; c = cyc;
    expectAt(c + 1, 3'b111, 3'b111, 3'b111, 3'b010, 0, 3'b000, "R1");
    step(2);

    // R2: open-drain
    cfgOpenDrain = 3'b111; c = cyc;
    expectAt(c + 1, 3'b111, 3'b101, 3'b111, 3'b000, 0, 3'b000, "R2");
    step(1);
    gpoData = 3'b101; c = cyc;
    expectAt(c + 1, 3'b111, 3'b010, 3'b111, 3'b000, 0, 3'b000, "R2");
    step(2);

    // R12: two-stage synchronizer
    padIn = 3'b101; c = cyc;
    expectAt(c + 1, 3'b000, 3'b000, 3'b000, 3'b000, 1, 3'b000, "R12");
    expectAt(c + 2, 3'b000, 3'b000, 3'b000, 3'b000, 1, 3'b101, "R12");
    step(3);
    padIn = 3'b011; c = cyc;
    expectAt(c + 1, 3'b000, 3'b000, 3'b000, 3'b000, 1, 3'b101, "R12");
    expectAt(c + 2, 3'b000, 3'b000, 3'b000, 3'b000, 1, 3'b011, "R12");
    step(3);

    // R4 / R5: lamp mode, no cable
    cfgLedEn = 3'b111; c = cyc;
    expectAt(c + 1, 3'b111, 3'b001, 3'b111, 3'b000, 0, 3'b000, "R4");
    step(2);

    // R5 / R6: link up while negotiating
    linkUp = 1; autoNegBusy = 1; c = cyc;
    expectAt(c + 1, 3'b111, 3'b011, 3'b111, 3'b000, 0, 3'b000, "R6");
    step(2);
    autoNegBusy = 0; c = cyc;
    expectAt(c + 1, 3'b001, 3'b000, 3'b000, 3'b000, 0, 3'b000, "R5");
    step(2);
    speed100 = 1; c = cyc;
    expectAt(c + 1, 3'b001, 3'b001, 3'b000, 3'b000, 0, 3'b000, "R5");
    step(2);

    // R9: duplex lamp
    fullDuplex = 1; c = cyc;
    expectAt(c + 1, 3'b100, 3'b100, 3'b000, 3'b000, 0, 3'b000, "R9");
    step(2);
    fullDuplex = 0; c = cyc;
    expectAt(c + 1, 3'b100, 3'b000, 3'b000, 3'b000, 0, 3'b000, "R9");
    step(2);

    // R7: single blink of exact length
    c = cyc;
    expectAt(c + 1,         3'b010, 3'b010, 3'b010, 3'b000, 0, 3'b000, "R7");
    expectAt(c + 2,         3'b010, 3'b000, 3'b010, 3'b000, 0, 3'b000, "R7");
    expectAt(c + B + 1,     3'b010, 3'b000, 3'b000, 3'b000, 0, 3'b000, "R7");
    expectAt(c + B + 2,     3'b010, 3'b010, 3'b000, 3'b000, 0, 3'b000, "R7");
    expectAt(c + 2 * B + 4, 3'b010, 3'b010, 3'b000, 3'b000, 0, 3'b000, "R8");
    pulse(1);
    step(2 * B + 6);

    // R8: activity during the dark period is remembered
    c = cyc;
    expectAt(c + B + 2,     3'b010, 3'b010, 3'b000, 3'b000, 0, 3'b000, "R8");
    expectAt(c + 2 * B + 1, 3'b010, 3'b010, 3'b000, 3'b000, 0, 3'b000, "R8");
    expectAt(c + 2 * B + 2, 3'b010, 3'b000, 3'b000, 3'b000, 0, 3'b000, "R8");
    expectAt(c + 3 * B + 1, 3'b010, 3'b000, 3'b000, 3'b000, 0, 3'b000, "R8");
    expectAt(c + 3 * B + 2, 3'b010, 3'b010, 3'b000, 3'b000, 0, 3'b000, "R8");
    expectAt(c + 4 * B + 4, 3'b010, 3'b010, 3'b000, 3'b000, 0, 3'b000, "R8");
    pulse(0);
    step(2);
    pulse(0);
    step(4 * B + 6);

    // R8: activity during the hold is remembered
    c = cyc;
    expectAt(c + 2 * B + 1, 3'b010, 3'b010, 3'b000, 3'b000, 0, 3'b000, "R8");
    expectAt(c + 2 * B + 2, 3'b010, 3'b000, 3'b000, 3'b000, 0, 3'b000, "R8");
    pulse(1);
    step(B + 3);
    pulse(0);
    step(3 * B + 6);

    // R10: link drop mid-blink, activity while down, clean re-link
    c = cyc;
    pulse(1);
    step(2);
    linkUp = 0;
    expectAt(c + 4,     3'b010, 3'b000, 3'b000, 3'b000, 0, 3'b000, "R10");
    expectAt(c + 8,     3'b010, 3'b000, 3'b000, 3'b000, 0, 3'b000, "R10");
    step(3);
    pulse(1);
    step(1);
    linkUp = 1;
    expectAt(c + 9,     3'b010, 3'b010, 3'b000, 3'b000, 0, 3'b000, "R10");
    expectAt(c + 11,    3'b010, 3'b010, 3'b000, 3'b000, 0, 3'b000, "R10");
    expectAt(c + B + 12, 3'b010, 3'b010, 3'b000, 3'b000, 0, 3'b000, "R10");
    step(B + 6);

    // R11: leaving lamp mode restores GPIO on the next clock
    cfgOpenDrain = 3'b000; gpoData = 3'b010;
    step(2);
    cfgLedEn = 3'b101; c = cyc;
    expectAt(c + 1, 3'b010, 3'b010, 3'b010, 3'b010, 0, 3'b000, "R11");
    step(4);

    while (sb.size() != 0) step(1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule